// File: doc/BRIEF.md
# Pipelined Multi-Lane Single-Precision Exponential Unit

This unit evaluates e^x on several IEEE-754 single-precision operands at once. Each lane takes a 32-bit operand and returns a 32-bit result. A request carries a lane mask and a tag. Both travel with the data, so a downstream consumer can match each answer to its request. One request can be taken in every cycle. Every answer comes out a fixed number of cycles later, unless the consumer applies backpressure. In that case the whole pipeline freezes and keeps its contents.

Inside each lane the operand is first split into k·ln2 + r, with |r| held near ln2/2. Next, a degree-seven polynomial in fixed point approximates e^r. The result exponent is then built from k; results below the normal range are shifted right into subnormals. Special operands bypass the arithmetic. Each lane produces a five-bit exception word. The unit returns the OR of the words of the lanes selected by the mask of that request. Results are accurate to a few units in the last place; they are not correctly rounded.

Top module: `fexp_simd`

## Requirements
- R1: A request accepted at a rising edge (in_valid and in_ready both high) appears on out_valid, out_data and out_tag eight cycles later, provided out_ready stays high. Tags come out in acceptance order. The pipeline never holds more than eight requests.
- R2: in_ready is low exactly when out_valid is high and out_ready is low. During such a stall, out_valid, out_data, out_tag and out_flags hold their values.
- R3: The exception word uses bit 0 for inexact, bit 1 for underflow and bit 2 for overflow; bits 3 and 4 are always 0. A finite operand whose e^x lies in the representable range gets a lane word of 0x01. Its result is within 2^-21 relative, or within 2^-147 absolute, of the exact value. This covers zero and subnormal operands, which give about 1.0.
- R4: A finite operand whose e^x exceeds the largest finite float (x above about 88.72) returns +inf (0x7F800000) with lane word 0x05.
- R5: A finite negative operand whose e^x is below half the smallest subnormal (x below about -103.97) returns +0 (0x00000000) with lane word 0x03.
- R6: +inf returns +inf, -inf returns +0 and any NaN returns 0x7FC00000, each with lane word 0x00.
- R7: out_flags is the OR of the lane words of the lanes whose bit is set in the mask that came with the request; an all-zero mask gives 0x00. Every lane produces its result whatever the mask.
- R8: out_has_flags is always 1.
- R9: While rst_n is low and right after it is released, out_valid is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A request is offered |
| in_ready | output | 1 | The unit takes the offered request at this edge |
| in_mask | input | LANES | Lanes whose exception words enter the merged word |
| in_tag | input | TAG_W | Request identifier returned with the result |
| in_data | input | LANES x 32 | Single-precision operand of each lane |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The consumer takes the presented result |
| out_data | output | LANES x 32 | e^x of each lane |
| out_tag | output | TAG_W | Tag of the presented result |
| out_flags | output | 5 | Merged exception word (bit 0 inexact, 1 underflow, 2 overflow) |
| out_has_flags | output | 1 | Always 1: the result carries exception flags |

## Verification
The properties assume that reset is applied before the first request, and that out_ready and in_valid are free inputs sampled only at the rising edge. The occupancy count also assumes that a result counts as delivered only in a cycle where out_valid and out_ready are both high. The bench drives every input half a cycle away from the sampling edge. Backpressure only changes just after an edge, so the ready decision is settled before the driver reads it. Operands near the overflow and underflow thresholds are avoided on purpose, because a few units of error there could change the class of the result. The random operands lie on a 0.001 grid, which also keeps them off those thresholds.

// File: rtl/fexp_pkg.sv
package fexp_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int FW     = 32;
  localparam int FLAG_W = 5;
  localparam int FRAC   = 30;

  localparam logic [31:0] INV_LN2_Q30 = 32'd1549082005;
  localparam logic [31:0] LN2_Q30     = 32'd744261118;

  // 1/i! in Q30, index i = 0..7
  localparam logic signed [33:0] COEF [8] = '{
    34'sd1073741824, 34'sd1073741824, 34'sd536870912, 34'sd178956971,
    34'sd44739243,   34'sd8947849,    34'sd1491308,   34'sd213044
  };

  localparam logic [31:0] POS_INF   = 32'h7F80_0000;
  localparam logic [31:0] QNAN      = 32'h7FC0_0000;
  localparam logic [4:0]  FL_NX     = 5'h01;
  localparam logic [4:0]  FL_UF_NX  = 5'h03;
  localparam logic [4:0]  FL_OF_NX  = 5'h05;

  typedef enum logic [1:0] {K_NUM, K_NAN, K_PINF, K_NINF} kind_e;

  typedef struct packed {
    kind_e              kind;
    logic signed [9:0]  k;
    logic signed [31:0] r;
  } red_t;

  typedef struct packed {
    logic [FW-1:0]     res;
    logic [FLAG_W-1:0] flg;
  } lane_out_t;
endpackage

// File: rtl/fexp_delay.sv
module fexp_delay #(
  parameter int W     = 1,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [W-1:0] q  [DEPTH];
  logic [W-1:0] nx [DEPTH];

  always_comb begin
    nx[0] = din;
    for (int i = 1; i < DEPTH; i++) nx[i] = q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (en) begin
      q <= nx;
    end
  end

  assign dout = q[DEPTH-1];
endmodule

// File: rtl/fexp_reduce.sv
module fexp_reduce
  import fexp_pkg::*;
(
  input  logic [31:0] x,
  output red_t        f
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [7:0]  e, ee;
  logic [23:0] mant;
  logic [39:0] xa;
  logic [7:0]  ka;
  logic [31:0] rm;

  always_comb begin
    e    = x[30:23];
    ee   = (e == 8'd0) ? 8'd1 : e;
    mant = {|e, x[22:0]};
    xa   = '0;
    ka   = '0;
    rm   = '0;
    f    = '0;
    f.kind = K_NUM;
    if (e == 8'hFF) begin
      f.kind = (|x[22:0]) ? K_NAN : (x[31] ? K_NINF : K_PINF);
    end else if (ee >= 8'd134) begin
      // |x| >= 128: saturate k so the assembler overflows or flushes
      f.k = x[31] ? -10'sd300 : 10'sd300;
    end else begin
      if (ee >= 8'd120) xa = 40'(mant) << (ee - 8'd120);
      else              xa = 40'(mant) >> (8'd120 - ee);
      ka  = 8'((80'(xa) * 80'(INV_LN2_Q30) + (80'd1 << 59)) >> 60);
      rm  = 32'(42'(xa) - 42'(ka) * 42'(LN2_Q30));
      f.k = x[31] ? -$signed({2'b00, ka}) : $signed({2'b00, ka});
      f.r = x[31] ? -$signed(rm) : $signed(rm);
    end
  end
endmodule

// File: rtl/fexp_eval.sv
module fexp_eval
  import fexp_pkg::*;
(
  input  red_t      f,
  output lane_out_t o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic signed [33:0] acc;
  logic signed [11:0] be;
  logic [63:0]        pn, rnd, bits;
  int                 sh, base;

  always_comb begin
    acc = COEF[7];
    for (int i = 6; i >= 0; i--) begin
      acc = COEF[i] + 34'((66'(acc) * 66'(f.r)) >>> FRAC);
    end
    pn = acc[30] ? 64'(acc) : (64'(acc) << 1);
    be = 12'(f.k) + (acc[30] ? 12'sd127 : 12'sd126);
    if (be > 12'sd0) begin
      sh   = 7;
      base = int'(be) - 1;
    end else begin
      sh   = 8 - int'(be);
      if (sh > 40) sh = 40;
      base = 0;
    end
    rnd  = (pn + (64'd1 << (sh - 1))) >> sh;
    bits = (64'(base) << 23) + rnd;
    case (f.kind)
      K_NAN:  begin o.res = QNAN;    o.flg = '0; end
      K_PINF: begin o.res = POS_INF; o.flg = '0; end
      K_NINF: begin o.res = '0;      o.flg = '0; end
      default: begin
        if (bits >= 64'h7F80_0000) begin
          o.res = POS_INF; o.flg = FL_OF_NX;
        end else if (bits == 64'd0) begin
          o.res = '0;      o.flg = FL_UF_NX;
        end else begin
          o.res = bits[31:0]; o.flg = FL_NX;
        end
      end
    endcase
  end
endmodule

// File: rtl/fexp_lane.sv
module fexp_lane
  import fexp_pkg::*;
#(
  parameter int STAGES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [FW-1:0] din,
  output logic [FW-1:0] res,
  output logic [4:0]    flg
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TAIL = STAGES - 1;

  red_t      red_c, red_q;
  lane_out_t out_c, out_q;

  fexp_reduce u_red (.x(din), .f(red_c));

  fexp_delay #(.W($bits(red_t)), .DEPTH(1)) u_red_q (
    .clk(clk), .rst_n(rst_n), .en(en), .din(red_c), .dout(red_q)
  );

  fexp_eval u_eval (.f(red_q), .o(out_c));

  fexp_delay #(.W($bits(lane_out_t)), .DEPTH(TAIL)) u_out_q (
    .clk(clk), .rst_n(rst_n), .en(en), .din(out_c), .dout(out_q)
  );

  assign res = out_q.res;
  assign flg = out_q.flg;
endmodule

// File: rtl/fexp_simd.sv
module fexp_simd
  import fexp_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int TAG_W  = 6,
  parameter int STAGES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic [LANES-1:0]           in_mask,
  input  logic [TAG_W-1:0]           in_tag,
  input  logic [LANES-1:0][FW-1:0]   in_data,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [LANES-1:0][FW-1:0]   out_data,
  output logic [TAG_W-1:0]           out_tag,
  output logic [FLAG_W-1:0]          out_flags,
  output logic                       out_has_flags
);
  timeunit 1ns;
  timeprecision 1ps;

  logic                          adv;
  logic [LANES-1:0]              mask_d;
  logic [LANES-1:0][FLAG_W-1:0]  lane_flg;

  assign adv      = !(out_valid && !out_ready);
  assign in_ready = adv;

  fexp_delay #(.W(1), .DEPTH(STAGES)) u_vld (
    .clk(clk), .rst_n(rst_n), .en(adv), .din(in_valid), .dout(out_valid)
  );

  fexp_delay #(.W(LANES + TAG_W), .DEPTH(STAGES)) u_side (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .din({in_mask, in_tag}), .dout({mask_d, out_tag})
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fexp_lane #(.STAGES(STAGES)) u_lane (
      .clk(clk), .rst_n(rst_n), .en(adv),
      .din(in_data[g]), .res(out_data[g]), .flg(lane_flg[g])
    );
  end

  always_comb begin
    out_flags = '0;
    for (int i = 0; i < LANES; i++) begin
      if (mask_d[i]) out_flags = out_flags | lane_flg[i];
    end
  end

  assign out_has_flags = 1'b1;
endmodule

// File: rtl/fexp_simd_chk.sv
module fexp_simd_chk #(
  parameter int LANES  = 4,
  parameter int TAG_W  = 6,
  parameter int STAGES = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES-1:0][31:0]  out_data,
  input logic [TAG_W-1:0]        out_tag,
  input logic [4:0]              out_flags,
  input logic [LANES-1:0]        mask_d
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = $clog2(STAGES + 2) + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else cnt <= cnt + CW'(in_valid && in_ready) - CW'(out_valid && out_ready);
  end

  // R1
  inflight_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(STAGES));

  // R1
  empty_no_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !out_valid);

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_tag) && $stable(out_flags)));

  // R2
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R3
  flag_imply_nx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (out_flags[2] || out_flags[1])) |-> out_flags[0]);

  // R3
  flag_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[4:3] == 2'b00));

  // R7
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mask_d == '0) |-> (out_flags == 5'h00));

  for (genvar g = 0; g < LANES; g++) begin : g_nan
    // R6
    nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_data[g][30:23] == 8'hFF && out_data[g][22:0] != 23'd0)
        |-> (out_data[g] == 32'h7FC0_0000));
  end
endmodule

bind fexp_simd fexp_simd_chk #(.LANES(LANES), .TAG_W(TAG_W), .STAGES(STAGES)) u_chk (.*);

// File: tb/fexp_simd_test.sv
module fexp_simd_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LANES = 4;
  localparam int TAG_W = 6;

  logic                     clk = 1'b0;
  logic                     rst_n;
  logic                     in_valid;
  logic                     in_ready;
  logic [LANES-1:0]         in_mask;
  logic [TAG_W-1:0]         in_tag;
  logic [LANES-1:0][31:0]   in_data;
  logic                     out_valid;
  logic                     out_ready;
  logic [LANES-1:0][31:0]   out_data;
  logic [TAG_W-1:0]         out_tag;
  logic [4:0]               out_flags;
  logic                     out_has_flags;

  fexp_simd #(.LANES(LANES), .TAG_W(TAG_W), .STAGES(8)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mask(in_mask), .in_tag(in_tag), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_tag(out_tag), .out_flags(out_flags), .out_has_flags(out_has_flags)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [LANES-1:0][31:0] d;
    logic [LANES-1:0]       m;
    logic [TAG_W-1:0]       t;
    int                     c;
  } item_t;

  item_t            sb[$];
  int               n_chk = 0;
  int               n_fail = 0;
  bit               bp_on = 1'b0;
  bit               lat_on = 1'b1;
  logic [TAG_W-1:0] tagc = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  function automatic real b2r(input logic [31:0] b);
    real m;
    if (b[30:23] == 8'd0) m = real'(b[22:0]) * $pow(2.0, -149.0);
    else m = (8388608.0 + real'(b[22:0])) * $pow(2.0, real'(int'(b[30:23]) - 150));
    return b[31] ? -m : m;
  endfunction

  function automatic logic [31:0] r2b(input real v);
    real a;
    int  e, mt;
    if (v == 0.0) return 32'd0;
    a = (v < 0.0) ? -v : v;
    e = 127;
    while (a >= 2.0) begin a = a / 2.0; e++; end
    while (a < 1.0)  begin a = a * 2.0; e--; end
    mt = int'((a - 1.0) * 8388608.0);
    if (mt >= 8388608) begin mt = 0; e++; end
    return {(v < 0.0), 8'(e), 23'(mt)};
  endfunction

  function automatic void lane_exp(input logic [31:0] b, output logic [31:0] er,
                                   output logic [4:0] ef, output bit exact,
                                   output real rr, output string req);
    rr = 0.0;
    er = '0;
    if (b[30:23] == 8'hFF) begin
      exact = 1'b1; ef = 5'h00; req = "R6";
      er = (b[22:0] != 23'd0) ? 32'h7FC0_0000 : (b[31] ? 32'h0 : 32'h7F80_0000);
    end else begin
      rr = $exp(b2r(b));
      if (rr >= 3.4028235677973366e38) begin
        exact = 1'b1; er = 32'h7F80_0000; ef = 5'h05; req = "R4";
      end else if (rr < 7.006492321624085e-46) begin
        exact = 1'b1; er = 32'h0; ef = 5'h03; req = "R5";
      end else begin
        exact = 1'b0; ef = 5'h01; req = "R3";
      end
    end
  endfunction

  // driver: caller is at a falling edge
  task automatic send(input logic [LANES-1:0] m, input logic [LANES-1:0][31:0] d);
    item_t it;
    in_valid = 1'b1;
    in_mask  = m;
    in_data  = d;
    in_tag   = tagc;
    while (!in_ready) @(negedge clk);
    it.d = d; it.m = m; it.t = tagc; it.c = cyc;
    sb.push_back(it);
    tagc = tagc + 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // backpressure source, changes just after the rising edge
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #1;
      out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && out_valid && out_ready) begin
        item_t it;
        logic [4:0] fexp;
        if (sb.size() == 0) begin
          chk(1'b0, "R1", "unexpected result", {26'd0, out_tag}, 32'd0);
        end else begin
          it = sb.pop_front();
          fexp = '0;
          chk(out_tag == it.t, "R1", "tag order", {26'd0, out_tag}, {26'd0, it.t});
          if (lat_on)
            chk(cyc - it.c == 8, "R1", "latency", 32'(cyc - it.c), 32'd8);
          chk(out_has_flags == 1'b1, "R8", "has_flags", {31'd0, out_has_flags}, 32'd1);
          for (int i = 0; i < LANES; i++) begin
            logic [31:0] er;
            logic [4:0]  ef;
            bit          exact;
            real         rr, got, tol, dif;
            string       req;
            lane_exp(it.d[i], er, ef, exact, rr, req);
            if (it.m[i]) fexp = fexp | ef;
            if (exact) begin
              chk(out_data[i] == er, req, $sformatf("lane %0d of x=%h", i, it.d[i]),
                  out_data[i], er);
            end else begin
              got = b2r(out_data[i]);
              tol = rr * $pow(2.0, -21.0);
              if (tol < $pow(2.0, -147.0)) tol = $pow(2.0, -147.0);
              dif = got - rr;
              if (dif < 0.0) dif = -dif;
              n_chk++;
              if (out_data[i][30:23] == 8'hFF || dif > tol) begin
                n_fail++;
                $display("FAIL R3 lane %0d of x=%h: got %h (%g) expected %g",
                         i, it.d[i], out_data[i], got, rr);
              end
            end
          end
          chk(out_flags == fexp, "R7", $sformatf("merged flags mask %b", it.m),
              {27'd0, out_flags}, {27'd0, fexp});
        end
      end
    end
  end

  // stall behaviour seen at the ports
  initial begin
    bit                     prev_stall = 1'b0;
    logic [LANES-1:0][31:0] prev_data;
    logic [TAG_W-1:0]       prev_tag;
    forever begin
      @(negedge clk);
      if (rst_n && bp_on) begin
        chk(in_ready == !(out_valid && !out_ready), "R2", "in_ready rule",
            {31'd0, in_ready}, {31'd0, !(out_valid && !out_ready)});
        if (prev_stall)
          chk(out_valid && out_data == prev_data && out_tag == prev_tag, "R2",
              "held during stall", out_data[0], prev_data[0]);
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      prev_tag   = out_tag;
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  logic [LANES-1:0][31:0] v_big;

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_mask  = '0;
    in_tag   = '0;
    in_data  = '0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", {31'd0, out_valid}, 32'd0);
    chk(in_ready == 1'b1, "R9", "in_ready after reset", {31'd0, in_ready}, 32'd1);

    // R3 ordinary values, back to back
    send(4'hF, {32'h3F00_0000, 32'hBF80_0000, 32'h3F80_0000, 32'h0000_0000});
    send(4'hF, {32'hC2AE_0000, 32'h42B0_0000, 32'hC120_0000, 32'h4120_0000});
    // R3 subnormal and tiny operands give about 1.0
    send(4'hF, {32'h8040_0000, 32'h0000_0001, 32'h3380_0000, 32'hB380_0000});
    // R6 special operands
    send(4'hF, {32'hFFC0_0000, 32'h7F80_0001, 32'hFF80_0000, 32'h7F80_0000});
    // R4 / R5 saturation and a subnormal result
    v_big = {32'hC2C8_0000, 32'h4348_0000, 32'hC2DC_0000, 32'h42B2_0000};
    send(4'hF, v_big);
    // R7 mask selection of lane words
    send(4'b0001, v_big);
    send(4'b0010, v_big);
    send(4'b0000, v_big);
    send(4'b1000, v_big);
    idle();
    wait (sb.size() == 0);
    repeat (2) @(negedge clk);

    // random operands, no backpressure, latency checked
    for (int n = 0; n < 24; n++) begin
      logic [LANES-1:0][31:0] d;
      for (int i = 0; i < LANES; i++)
        d[i] = r2b((real'($urandom_range(0, 180000)) - 90000.0) / 1000.0);
      send(4'($urandom), d);
    end
    idle();
    wait (sb.size() == 0);
    repeat (2) @(negedge clk);

    // R2 random backpressure with gaps
    lat_on = 1'b0;
    bp_on  = 1'b1;
    for (int n = 0; n < 60; n++) begin
      logic [LANES-1:0][31:0] d;
      for (int i = 0; i < LANES; i++)
        d[i] = r2b((real'($urandom_range(0, 180000)) - 90000.0) / 1000.0);
      if ($urandom % 4 == 0) idle();
      send(4'($urandom), d);
    end
    idle();
    wait (sb.size() == 0);
    bp_on = 1'b0;
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule